// File: doc/BRIEF.md
# Multi-Mode Shutdown Request Qualifier

The block watches three active-low external shutdown request pins and decides, channel by channel, when a genuine request has arrived. Each pin first crosses a two-flop synchronizer. A per-channel mode field then selects one of two rules. Edge mode accepts a high-to-low transition. Filter mode accepts a request only after sixteen consecutive low samples, taken at the clock divided by 8, 16 or 128. A single free-running prescaler supplies the three sample strobes.

An accepted request sets a sticky flag for that channel. The combined request output is high while any flag is set. Software writes the mode fields over a small register port, and only the first write after reset is taken. A flag clears only when software reads it as 1 and then writes 0 to it.

Each channel runs a three-state machine that advances only on its sample strobe. In edge mode the strobe fires on every clock.
- ST_HOLD: the reset state, and the state after an accept. A high sample moves it to ST_ARM. A low sample keeps it in ST_HOLD.
- ST_ARM: a high sample keeps it in ST_ARM with the count at zero. A low sample moves it to ST_HOLD with an accept in edge mode, and to ST_COUNT with the count at 1 in filter mode.
- ST_COUNT: a high sample moves it back to ST_ARM and clears the count. A low sample increments the count, and the sixteenth low sample moves it to ST_HOLD with an accept.

Top module: `req_qualifier`

## Requirements
- R1: After reset, flag_o is 000, req_o is 0, the mode register at addr 0 reads 0 and the flag register at addr 1 reads 0.
- R2: In mode 00 (edge), a high-to-low transition on req_n_i[i] sets flag_o[i]. The flag is set on the third rising clock edge after the pin changes.
- R3: In mode 01, flag_o[i] is set after 16 consecutive low samples taken once every 8 clocks. A low lasting only 80 clocks sets nothing.
- R4: In mode 10, samples are taken once every 16 clocks. A low of 192 clocks sets nothing, although the same low would pass at the divide-by-8 rate. A low of 400 clocks sets the flag.
- R5: In mode 11, samples are taken once every 128 clocks. A low of 1500 clocks sets nothing and a low of 2600 clocks sets the flag.
- R6: A high sample in the middle of a run of lows restarts the count from zero.
- R7: After an accept, a channel accepts nothing more until it has seen a high sample. This holds in both edge and filter modes.
- R8: The mode register is at addr 0, with channel 0 in bits 1:0, channel 1 in bits 3:2 and channel 2 in bits 5:4. Only the first write after reset is taken, and later writes are ignored.
- R9: The flags are at addr 1, with channel i in bit i. A write of 0 to bit i clears flag i only if the previous flag-register access was a read that returned 1 in that bit. A write of 0 without that read, and a write of 1, leave the flag unchanged.
- R10: When an accept and a valid clear hit the same flag in the same clock, the flag stays at 1.
- R11: req_o is high exactly when at least one flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the block and the source of the prescaler |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_n_i | input | 3 | Active-low request pins, one per channel |
| addr | input | 1 | Register select: 0 selects the mode register, 1 selects the flag register |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe, which arms flag clearing |
| wdata | input | 6 | Write data |
| rdata | output | 6 | Read data for the register selected by addr |
| flag_o | output | 3 | Sticky per-channel request flags |
| req_o | output | 1 | OR of all the flags |

## Verification
The pins are driven with single falling edges, with lows held past an accept, and with low bursts of chosen lengths. Those lengths are picked so that a burst fires at one sample rate and not at the next slower one, which separates the three divide ratios from each other and from edge mode. A burst that is split by a short high interval checks that the count restarts rather than carrying over. Register sequences test the clear rule in its three forms (write without a read, write of 1, and read followed by write of 0), repeat the mode write to check that later writes are ignored, and place a clear in the same clock as a new accept to check that the set takes priority.

// File: rtl/qual_pkg.sv
package qual_pkg;
    typedef enum logic [1:0] {
        MODE_EDGE  = 2'b00,
        MODE_DIV_A = 2'b01,
        MODE_DIV_B = 2'b10,
        MODE_DIV_C = 2'b11
    } qmode_t;

    typedef enum logic [1:0] {
        ST_HOLD  = 2'b00,
        ST_ARM   = 2'b01,
        ST_COUNT = 2'b10
    } qstate_t;

    localparam logic ADDR_MODE = 1'b0;
    localparam logic ADDR_FLAG = 1'b1;
endpackage

// File: rtl/qual_prescaler.sv
module qual_prescaler #(
    parameter int DIV_A = 8,
    parameter int DIV_B = 16,
    parameter int DIV_C = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    output logic [2:0] strobe
);
    localparam int CW = $clog2(DIV_C);
    localparam int LA = $clog2(DIV_A);
    localparam int LB = $clog2(DIV_B);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    // each strobe lasts one clock when the low bits of the counter wrap
    assign strobe[0] = (cnt_q[LA-1:0] == '1);
    assign strobe[1] = (cnt_q[LB-1:0] == '1);
    assign strobe[2] = (cnt_q == '1);
endmodule

// File: rtl/qual_channel.sv
module qual_channel
    import qual_pkg::*;
#(
    parameter int SAMPLES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_n,
    input  qmode_t     mode,
    input  logic [2:0] strobe,
    output logic       hit
);
    localparam int CW = $clog2(SAMPLES + 1);

    logic [1:0]    sync_q;
    logic          s_in;
    logic          sample_en;
    logic [CW-1:0] limit;
    logic [CW-1:0] cnt_q, cnt_d;
    qstate_t       state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], pin_n};
    end
    assign s_in = sync_q[1];

    always_comb begin
        unique case (mode)
            MODE_EDGE:  sample_en = 1'b1;
            MODE_DIV_A: sample_en = strobe[0];
            MODE_DIV_B: sample_en = strobe[1];
            MODE_DIV_C: sample_en = strobe[2];
        endcase
    end

    assign limit = (mode == MODE_EDGE) ? CW'(1) : CW'(SAMPLES);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state and accept pulse
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        hit     = 1'b0;
        if (sample_en) begin
            if (s_in) begin
                state_d = ST_ARM;
                cnt_d   = '0;
            end else begin
                unique case (state_q)
                    ST_HOLD: begin
                        state_d = ST_HOLD;
                    end
                    ST_ARM: begin
                        if (limit == CW'(1)) begin
                            hit     = 1'b1;
                            state_d = ST_HOLD;
                        end else begin
                            cnt_d   = CW'(1);
                            state_d = ST_COUNT;
                        end
                    end
                    ST_COUNT: begin
                        if (cnt_q + 1'b1 >= limit) begin
                            hit     = 1'b1;
                            cnt_d   = '0;
                            state_d = ST_HOLD;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                    default: begin
                        state_d = ST_HOLD;
                        cnt_d   = '0;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/qual_regs.sv
module qual_regs
    import qual_pkg::*;
#(
    parameter int NCH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             addr,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [2*NCH-1:0] wdata,
    input  logic [NCH-1:0]   hit,
    output logic [2*NCH-1:0] rdata,
    output logic [2*NCH-1:0] mode_q,
    output logic [NCH-1:0]   flag_q
);
    logic           locked_q;
    logic [NCH-1:0] armed_q;
    logic [NCH-1:0] clr;
    logic           wr_flag;

    assign wr_flag = wr_en && (addr == ADDR_FLAG);
    assign clr     = wr_flag ? (armed_q & ~wdata[NCH-1:0]) : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= '0;
            locked_q <= 1'b0;
            flag_q   <= '0;
            armed_q  <= '0;
        end else begin
            if (wr_en && (addr == ADDR_MODE) && !locked_q) begin
                mode_q   <= wdata;
                locked_q <= 1'b1;
            end
            if (rd_en && (addr == ADDR_FLAG)) armed_q <= flag_q;
            if (wr_flag)                      armed_q <= '0;
            // a new accept overrides a clear in the same clock
            flag_q <= (flag_q & ~clr) | hit;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_MODE) rdata = mode_q;
        else                   rdata[NCH-1:0] = flag_q;
    end
endmodule

// File: rtl/req_qualifier.sv
module req_qualifier
    import qual_pkg::*;
#(
    parameter int NCH     = 3,
    parameter int SAMPLES = 16,
    parameter int DIV_A   = 8,
    parameter int DIV_B   = 16,
    parameter int DIV_C   = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   req_n_i,
    input  logic             addr,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [2*NCH-1:0] wdata,
    output logic [2*NCH-1:0] rdata,
    output logic [NCH-1:0]   flag_o,
    output logic             req_o
);
    logic [2:0]       strobe;
    logic [NCH-1:0]   hit_v;
    logic [2*NCH-1:0] mode_w;

    qual_prescaler #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (strobe)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        qual_channel #(.SAMPLES(SAMPLES)) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_n  (req_n_i[i]),
            .mode   (qmode_t'(mode_w[2*i +: 2])),
            .strobe (strobe),
            .hit    (hit_v[i])
        );
    end

    qual_regs #(.NCH(NCH)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (addr),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .wdata  (wdata),
        .hit    (hit_v),
        .rdata  (rdata),
        .mode_q (mode_w),
        .flag_q (flag_o)
    );

    assign req_o = |flag_o;
endmodule

// File: rtl/qual_checker.sv
module qual_checker
    import qual_pkg::*;
#(
    parameter int NCH = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NCH-1:0]   hit,
    input logic [NCH-1:0]   flag,
    input logic             wr_en,
    input logic             addr,
    input logic [NCH-1:0]   wdata_lo,
    input logic [2*NCH-1:0] mode
);
    logic seen_mode_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                seen_mode_wr <= 1'b0;
        else if (wr_en && (addr == ADDR_MODE))     seen_mode_wr <= 1'b1;
    end

    // R8: once the first mode write has landed, the mode fields never move
    p_mode_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        seen_mode_wr |=> $stable(mode));

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        // R9: a flag drops only after a flag-register write with 0 in its bit
        p_fall_needs_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(flag[i]) |-> $past(wr_en && (addr == ADDR_FLAG) && !wdata_lo[i]));
        // R2: a flag rises only from an accept of its channel
        p_rise_needs_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag[i]) |-> $past(hit[i]));
        // R10: an accept always leaves the flag set, whatever the bus does
        p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
            hit[i] |=> flag[i]);
    end
endmodule

bind req_qualifier qual_checker #(.NCH(NCH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit      (hit_v),
    .flag     (flag_o),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata_lo (wdata[NCH-1:0]),
    .mode     (mode_w)
);

// File: tb/tb_req_qualifier.sv
`timescale 1ns/1ps
module tb_req_qualifier;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] req_n_i = 3'b111;
    logic       addr = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [5:0] wdata = '0;
    logic [5:0] rdata;
    logic [2:0] flag_o;
    logic       req_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic [3:0] exp_q[$];
    string      tag_q[$];

    req_qualifier dut (
        .clk(clk), .rst_n(rst_n), .req_n_i(req_n_i), .addr(addr),
        .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
        .flag_o(flag_o), .req_o(req_o)
    );

    always #2.5 clk = ~clk;

    // monitor: pops expected {req, flags} and compares at the falling edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [3:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            total++;
            if ({req_o, flag_o} !== e) begin
                bad++;
                $display("FAIL %s: req/flags actual=%b expected=%b", t, {req_o, flag_o}, e);
            end
        end
    end

    // driver side: push an expectation and let the monitor take it
    task automatic expect_out(input logic [2:0] fl, input string t);
        exp_q.push_back({|fl, fl});
        tag_q.push_back(t);
        @(negedge clk);
    endtask

    task automatic check_rd(input logic [5:0] act, input logic [5:0] e, input string t);
        total++;
        if (act !== e) begin
            bad++;
            $display("FAIL %s: rdata actual=%h expected=%h", t, act, e);
        end
    endtask

    task automatic bus_write(input logic a, input logic [5:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic a, output logic [5:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_all();
        logic [5:0] d;
        bus_read(1'b1, d);
        bus_write(1'b1, 6'h00);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
    end

    initial begin
        logic [5:0] d;
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(2);

        // R1 reset state
        expect_out(3'b000, "R1 reset outputs");
        bus_read(1'b0, d); check_rd(d, 6'h00, "R1 mode reg");
        bus_read(1'b1, d); check_rd(d, 6'h00, "R1 flag reg");

        // R2 edge mode (default 00) on channel 0, R11 combined output
        req_n_i[0] = 1'b0;
        wait_cyc(4);
        expect_out(3'b001, "R2 R11 edge sets flag0");

        // R9 clear rules
        bus_write(1'b1, 6'h00);
        expect_out(3'b001, "R9 write0 without read");
        bus_read(1'b1, d); check_rd(d, 6'h01, "R9 read flags");
        bus_write(1'b1, 6'h07);
        expect_out(3'b001, "R9 write1 no effect");
        bus_read(1'b1, d);
        bus_write(1'b1, 6'h00);
        expect_out(3'b000, "R9 R11 read1 then write0 clears");

        // R7 edge: pin held low gives no new accept
        wait_cyc(10);
        expect_out(3'b000, "R7 edge no re-accept while low");
        req_n_i[0] = 1'b1; wait_cyc(3);
        req_n_i[0] = 1'b0; wait_cyc(4);
        expect_out(3'b001, "R7 edge accept after high");
        clear_all();
        req_n_i[0] = 1'b1;

        // R10 set beats clear on channel 1
        req_n_i[1] = 1'b0; wait_cyc(4);
        expect_out(3'b010, "R10 setup flag1");
        req_n_i[1] = 1'b1; wait_cyc(4);
        bus_read(1'b1, d);
        req_n_i[1] = 1'b0;
        @(negedge clk);
        @(negedge clk);
        addr = 1'b1; wdata = 6'h00; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        expect_out(3'b010, "R10 set wins over clear");
        clear_all();
        expect_out(3'b000, "R10 later clear works");
        req_n_i[1] = 1'b1;

        // R8 write-once modes: ch0=10, ch1=01, ch2=11
        bus_write(1'b0, 6'h36);
        bus_read(1'b0, d); check_rd(d, 6'h36, "R8 first mode write");
        bus_write(1'b0, 6'h00);
        bus_read(1'b0, d); check_rd(d, 6'h36, "R8 second write ignored");
        wait_cyc(300);

        // R3 divide by 8 on channel 1
        req_n_i[1] = 1'b0; wait_cyc(80); req_n_i[1] = 1'b1;
        expect_out(3'b000, "R3 short low rejected");
        wait_cyc(20);
        req_n_i[1] = 1'b0; wait_cyc(200);
        expect_out(3'b010, "R3 long low accepted");
        req_n_i[1] = 1'b1;
        clear_all();
        wait_cyc(20);

        // R6 a high sample restarts the count
        req_n_i[1] = 1'b0; wait_cyc(80);
        req_n_i[1] = 1'b1; wait_cyc(20);
        req_n_i[1] = 1'b0; wait_cyc(80);
        req_n_i[1] = 1'b1;
        expect_out(3'b000, "R6 split burst rejected");
        wait_cyc(20);

        // R4 divide by 16 on channel 0
        req_n_i[0] = 1'b0; wait_cyc(192); req_n_i[0] = 1'b1;
        expect_out(3'b000, "R4 192 cycle low rejected");
        wait_cyc(40);
        req_n_i[0] = 1'b0; wait_cyc(400);
        expect_out(3'b001, "R4 400 cycle low accepted");
        req_n_i[0] = 1'b1;
        clear_all();
        wait_cyc(40);

        // R5 divide by 128 on channel 2, R7 filter
        req_n_i[2] = 1'b0; wait_cyc(1500); req_n_i[2] = 1'b1;
        expect_out(3'b000, "R5 1500 cycle low rejected");
        wait_cyc(300);
        req_n_i[2] = 1'b0; wait_cyc(2600);
        expect_out(3'b100, "R5 R11 2600 cycle low accepted");
        clear_all();
        wait_cyc(2600);
        expect_out(3'b000, "R7 filter no re-accept while low");
        req_n_i[2] = 1'b1; wait_cyc(300);
        req_n_i[2] = 1'b0; wait_cyc(2600);
        expect_out(3'b100, "R7 filter accept after high");
        req_n_i[2] = 1'b1;
        clear_all();
        expect_out(3'b000, "R9 final clear");

        wait_cyc(2);
        summary();
    end
endmodule